// File: doc/BRIEF.md
# Wired-NAND Interrupt Vector Generator

This block merges a small group of active-low interrupt request pins into the single active-high interrupt line of a processor. The processor sees only one request, however many pins are pulled low at the same time. When it acknowledges, the block drives an 8-bit vector onto the data bus.

The vector is not a priority-encoded index. It is the synchronized pin pattern itself, with the top bit forced to one. Each active (low) pin therefore clears its own bit of the vector. Every combination of simultaneous requests lands on its own entry in the upper half of a 256-entry vector table. Deciding which request to serve first is left to the handler software that sits at each entry.

The pins are treated as asynchronous and pass through a synchronizer. The vector is latched on the rising edge of the acknowledge strobe, so it stays stable for as long as the bus is driven.

Top module: `irqv_gen`

## Requirements
- R1: `int_o` is high exactly when at least one request pin, as seen after synchronization, is low. It is a single line, whatever the number of active pins.
- R2: With only pin k (k = 0..6) low at acknowledge, the vector is FFh with bit k cleared. Pin 0 gives FEh, pin 1 gives FDh, and pin 6 gives BFh.
- R3: With several pins low, each clears its own bit. Pins 0 and 1 together give FCh.
- R4: Bit 7 of every vector driven on the bus is 1.
- R5: A change on a request pin first shows on `int_o` after the third rising clock edge (two synchronizer flops, then the output register).
- R6: `drive_o` is high in the cycle that follows each rising clock edge at which `ack_i` is sampled high, and low otherwise. `data_o` is 00h whenever `drive_o` is low.
- R7: The vector is captured at the first edge where `ack_i` is high after being low. It is held unchanged while `ack_i` stays high, even if the pins change.
- R8: If no pin is active at the capturing edge, no new vector is captured. The bus then shows the previously captured vector.
- R9: A synchronous active-high reset clears `int_o`, `drive_o` and `data_o`, treats all pins as inactive and clears the stored vector to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_n_i | input | 7 | Asynchronous request pins, active low |
| ack_i | input | 1 | Acknowledge strobe from the processor, active high |
| int_o | output | 1 | Combined interrupt request, active high |
| drive_o | output | 1 | Data bus enable, high while the vector is driven |
| data_o | output | 8 | Interrupt vector, 00h while not driven |

## Verification
Each request pin is pulled low alone, which shows that the bit positions are not swapped or shifted. Pairs and larger groups, up to all seven pins, show that the bits combine and are not priority-encoded. An acknowledge given with no pin low shows that a stale vector is retained and not overwritten with FFh. Pins that toggle during a held acknowledge, and pins that are released while only in the synchronizer, show the capture stability and the three-edge request latency.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned NUM_REQ_DEF   = 7;
  localparam int unsigned VEC_W_DEF     = 8;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic [1:0] {
    ACK_IDLE = 2'b00,
    ACK_RISE = 2'b01,
    ACK_HELD = 2'b11,
    ACK_FALL = 2'b10
  } ack_phase_e;
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int unsigned WIDTH = 7,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] async_n_i,
  output logic [WIDTH-1:0] sync_n_o
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [WIDTH-1:0] stage_q [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '1;
          else       stage_q[g] <= async_n_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (rst_i) stage_q[g] <= '1;
          else       stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_n_o = stage_q[LAST];
endmodule

// File: rtl/irqv_combine.sv
module irqv_combine #(
  parameter int unsigned WIDTH = 7
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] sync_n_i,
  output logic             any_active_o,
  output logic             int_o
);
  // A NAND over the active-low pins: high when any pin is low.
  assign any_active_o = ~&sync_n_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) int_o <= 1'b0;
    else       int_o <= any_active_o;
  end
endmodule

// File: rtl/irqv_capture.sv
module irqv_capture
  import irqv_pkg::*;
#(
  parameter int unsigned WIDTH = 7,
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ack_i,
  input  logic             any_active_i,
  input  logic [WIDTH-1:0] sync_n_i,
  output logic             drive_o,
  output logic [VEC_W-1:0] data_o
);
  localparam int unsigned PAD_W = VEC_W - WIDTH;

  logic             ack_q;
  logic [VEC_W-1:0] vec_q;
  ack_phase_e       phase;
  logic             take;

  assign phase = ack_phase_e'({ack_q, ack_i});
  assign take  = (phase == ACK_RISE) && any_active_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ack_q   <= 1'b0;
      drive_o <= 1'b0;
    end else begin
      ack_q   <= ack_i;
      drive_o <= ack_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)     vec_q <= '0;
    else if (take) vec_q <= {{PAD_W{1'b1}}, sync_n_i};
  end

  assign data_o = drive_o ? vec_q : '0;
endmodule

// File: rtl/irqv_gen.sv
module irqv_gen
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_REQ    = NUM_REQ_DEF,
  parameter int unsigned VEC_W      = VEC_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_REQ-1:0] req_n_i,
  input  logic               ack_i,
  output logic               int_o,
  output logic               drive_o,
  output logic [VEC_W-1:0]   data_o
);
  logic [NUM_REQ-1:0] req_sync;
  logic               any_active;

  irqv_sync #(.WIDTH(NUM_REQ), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .async_n_i(req_n_i),
    .sync_n_o (req_sync)
  );

  irqv_combine #(.WIDTH(NUM_REQ)) u_comb (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sync_n_i    (req_sync),
    .any_active_o(any_active),
    .int_o       (int_o)
  );

  irqv_capture #(.WIDTH(NUM_REQ), .VEC_W(VEC_W)) u_cap (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .ack_i       (ack_i),
    .any_active_i(any_active),
    .sync_n_i    (req_sync),
    .drive_o     (drive_o),
    .data_o      (data_o)
  );
endmodule

// File: rtl/irqv_gen_chk.sv
module irqv_gen_chk #(
  parameter int unsigned NUM_REQ = 7,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_i,
  input logic               ack_i,
  input logic               int_o,
  input logic               drive_o,
  input logic [VEC_W-1:0]   data_o,
  input logic [NUM_REQ-1:0] req_sync
);
  // R1: request line follows the synchronized pins one edge later
  assert_int_nand_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (int_o == !(&$past(req_sync))));

  // R6: bus idle value
  assert_bus_zero_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !drive_o |-> (data_o == '0));

  // R6: enable tracks the sampled acknowledge
  assert_drive_follow_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (drive_o == $past(ack_i)));

  // R4: driven vectors lie in the upper half of the table
  assert_top_half_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (drive_o && data_o != '0) |-> data_o[VEC_W-1]);

  // R7: vector stable during a held acknowledge
  assert_vec_stable_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (drive_o && $past(drive_o) && !$past(rst_i)) |-> $stable(data_o));
endmodule

bind irqv_gen irqv_gen_chk #(.NUM_REQ(NUM_REQ), .VEC_W(VEC_W)) chk_i (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .ack_i   (ack_i),
  .int_o   (int_o),
  .drive_o (drive_o),
  .data_o  (data_o),
  .req_sync(req_sync)
);

// File: tb/irqv_gen_tb_top.sv
`timescale 1ns/100ps
module irqv_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] pins;
  logic       ack;
  logic       int_o;
  logic       drive_o;
  logic [7:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  irqv_gen dut_i (
    .clk_i  (clk),
    .rst_i  (rst),
    .req_n_i(pins),
    .ack_i  (ack),
    .int_o  (int_o),
    .drive_o(drive_o),
    .data_o (data_o)
  );

  // Behavioural reference: a queue of pin history, plain variables.
  logic [6:0] hist[$];
  logic       m_int;
  logic       m_drive;
  logic [7:0] m_vec;
  logic       m_ack_prev;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{7'h7f, 7'h7f, 7'h7f};
      m_int = 0; m_drive = 0; m_vec = 8'h00; m_ack_prev = 0;
    end else begin
      hist.push_front(pins);
      // hist[2] is the pin value from two edges before this one
      m_int = (hist[2] != 7'h7f);
      if (ack && !m_ack_prev && hist[2] != 7'h7f)
        m_vec = {1'b1, hist[2]};
      m_drive = ack;
      m_ack_prev = ack;
      void'(hist.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R1 int_o", int_o, m_int);
      check("R6 drive_o", drive_o, m_drive);
      check("R6 data_o", data_o, m_drive ? m_vec : 8'h00);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Apply a pattern, let it settle, acknowledge and check the vector.
  task automatic ack_with(input logic [6:0] p, input logic [7:0] exp, input string tag);
    pins = p;
    wait_cyc(4);
    ack = 1;
    @(negedge clk);
    check(tag, data_o, exp);
    check({tag, " R4 msb"}, data_o[7], 1);
    pins = ~p;         // R7: pins change while acknowledge is held
    wait_cyc(3);
    check("R7 held vector", data_o, exp);
    ack = 0;
    @(negedge clk);
    check("R6 bus released", data_o, 0);
    pins = 7'h7f;
    wait_cyc(4);
  endtask

  initial begin
    rst = 1; pins = 7'h7f; ack = 0;
    wait_cyc(3);
    check("R9 reset int", int_o, 0);
    check("R9 reset drive", drive_o, 0);
    check("R9 reset data", data_o, 0);
    @(negedge clk); rst = 0;
    wait_cyc(2);

    // R5: latency of exactly three edges
    pins = 7'h7b;
    @(negedge clk); check("R5 edge1", int_o, 0);
    @(negedge clk); check("R5 edge2", int_o, 0);
    @(negedge clk); check("R5 edge3", int_o, 1);
    pins = 7'h7f;
    wait_cyc(4);
    check("R1 idle", int_o, 0);

    // R2: each pin alone
    for (int k = 0; k < 7; k++) begin
      logic [6:0] p;
      p = 7'h7f & ~(7'd1 << k);
      ack_with(p, {1'b1, p}, "R2 single");
    end
    ack_with(7'h7e, 8'hfe, "R2 pin0 FE");
    ack_with(7'h3f, 8'hbf, "R2 pin6 BF");

    // R3: combinations
    ack_with(7'h7c, 8'hfc, "R3 pair FC");
    ack_with(7'h55, 8'hd5, "R3 mixed");
    ack_with(7'h00, 8'h80, "R3 all");

    // R8: acknowledge with no active pin keeps the last vector (80h)
    pins = 7'h7f;
    wait_cyc(4);
    check("R8 int low", int_o, 0);
    ack = 1;
    @(negedge clk);
    check("R8 retained", data_o, 8'h80);
    ack = 0;
    wait_cyc(2);

    // R1: a short pulse reaching only the first flop still propagates
    pins = 7'h6f;
    @(negedge clk);
    pins = 7'h7f;
    wait_cyc(2);
    check("R1 pulse seen", int_o, 1);
    wait_cyc(3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule